// File: doc/BRIEF.md
# Priority-Grouped Interrupt Pending Controller

This block gathers a set of level-sensitive interrupt lines and condenses them into one request towards a processor. Line numbers start at 16; the numbers below 16 belong to exceptions and are never accepted. Input position `k` of `irq_in` is line number `16 + k`. Each line has its own 4-bit priority register, where 0 is the most urgent level and 15 the least urgent. Software-side logic loads these registers through a one-cycle index/data write port.

Every cycle the block registers which lines are high as pending bits. From those bits and the priority registers it builds a 16-bit summary. Bit `p` of the summary is set when at least one pending line has priority `p`. A level bit therefore stays set while any other line at that level is still pending. The request to the processor is high whenever the summary is non-zero. The block also reports the most urgent pending level, and the lowest-numbered pending line at that level, so an interrupt handler can find its source without scanning.

The parameter `NUM_LINES` sets how many of the `MAX_LINES` input positions are live. Positions at or above `NUM_LINES` are ignored.

Top module: `irq_prio_pend_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until lines or writes occur, `pending`, `prio_summary`, `cpu_irq`, `top_prio` and `top_line` are all zero. Every priority register resets to 15, so a line asserted after reset sets summary bit 15.
- R2: `pending[k]` equals the level of `irq_in[k]` sampled at the previous rising clock edge, for every live position `k < NUM_LINES`. It follows the level, not edges.
- R3: `prio_summary[p]` is 1 exactly when some pending line has a priority register value of `p`.
- R4: When a pending line is released, its level bit in `prio_summary` stays set as long as another pending line still has the same priority.
- R5: `cpu_irq` is 1 exactly when `prio_summary` is non-zero. It drops only when no line at any level is pending.
- R6: `top_prio` is the index of the lowest set bit of `prio_summary` (0 is most urgent). It is 0 when nothing is pending.
- R7: `top_line` is `16 + k`, where `k` is the lowest live position that is pending at level `top_prio`. It is 0 when nothing is pending.
- R8: When `prio_wr_en` is 1 and `prio_wr_idx` is `16 + k` with `k < NUM_LINES`, the line's priority becomes `prio_wr_data` (4 bits) at the next rising edge. This also holds when the line is already pending, and the summary moves to the new level in that same cycle.
- R9: A write whose index is below 16, or at or above `16 + NUM_LINES`, changes no priority register.
- R10: Input positions at or above `NUM_LINES` never set a pending bit, a summary bit or the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | MAX_LINES | Interrupt levels; position k is line 16+k |
| prio_wr_en | input | 1 | Priority write strobe |
| prio_wr_idx | input | IDX_W | Line number addressed by the write |
| prio_wr_data | input | 4 | New priority level |
| pending | output | MAX_LINES | Registered pending bit per position |
| prio_summary | output | 16 | One bit per level with a pending line |
| cpu_irq | output | 1 | Request to the processor |
| top_prio | output | 4 | Most urgent pending level |
| top_line | output | IDX_W | Lowest pending line number at that level |

## Verification
Every result of this block is due one rising edge after its cause. A change on `irq_in` appears in `pending`, in the summary, in the request and in the selection outputs after the next edge. A priority write shows up in the summary one edge after the strobe is sampled. The bench drives inputs on the falling edge and samples on the falling edge that follows the single rising edge in between, so each check sits exactly one register stage after its stimulus. The sweep applies all 256 input patterns under three priority layouts, one of them with every line sharing a level. Directed cases cover release with a shared level, reprogramming a pending line, and out-of-range write indices.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int PRIO_LEVELS = 16;
  localparam int PRIO_W      = $clog2(PRIO_LEVELS);
  localparam int FIRST_LINE  = 16;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_IDLE = prio_t'(PRIO_LEVELS - 1);
endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int MAX_LINES = 8,
  parameter int NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MAX_LINES-1:0] irq_in,
  output logic [MAX_LINES-1:0] pend_q
);
  localparam logic [MAX_LINES-1:0] LIVE_MASK = (MAX_LINES'(1) << NUM_LINES) - MAX_LINES'(1);

  logic [MAX_LINES-1:0] pend_d;

  always_comb begin
    pend_d = irq_in & LIVE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_prio_pkg::*;
#(
  parameter int MAX_LINES = 8,
  parameter int NUM_LINES = 6,
  parameter int IDX_W     = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  prio_t                            wr_data,
  output logic [MAX_LINES-1:0][PRIO_W-1:0] prio_q
);
  for (genvar i = 0; i < MAX_LINES; i++) begin : g_slot
    if (i < NUM_LINES) begin : g_live
      logic  hit;
      prio_t nxt;
      prio_t cur;
      always_comb begin
        hit = wr_en && (wr_idx == IDX_W'(FIRST_LINE + i));
        nxt = hit ? wr_data : cur;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= PRIO_IDLE;
        else        cur <= nxt;
      end
      assign prio_q[i] = cur;
    end else begin : g_dead
      assign prio_q[i] = PRIO_IDLE;
    end
  end
endmodule

// File: rtl/irq_prio_summary.sv
module irq_prio_summary
  import irq_prio_pkg::*;
#(
  parameter int MAX_LINES = 8,
  parameter int IDX_W     = 8
) (
  input  logic [MAX_LINES-1:0]             pend,
  input  logic [MAX_LINES-1:0][PRIO_W-1:0] prio,
  output logic [PRIO_LEVELS-1:0]           summary,
  output prio_t                            top_prio,
  output logic [IDX_W-1:0]                 top_line
);
  for (genvar p = 0; p < PRIO_LEVELS; p++) begin : g_level
    logic [MAX_LINES-1:0] at_level;
    for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
      assign at_level[i] = pend[i] && (prio[i] == prio_t'(p));
    end
    assign summary[p] = |at_level;
  end

  always_comb begin
    top_prio = '0;
    for (int p = PRIO_LEVELS - 1; p >= 0; p--) begin
      if (summary[p]) top_prio = prio_t'(p);
    end
  end

  always_comb begin
    top_line = '0;
    for (int i = MAX_LINES - 1; i >= 0; i--) begin
      if (pend[i] && (prio[i] == top_prio)) top_line = IDX_W'(FIRST_LINE + i);
    end
  end
endmodule

// File: rtl/irq_prio_pend_ctrl.sv
module irq_prio_pend_ctrl
  import irq_prio_pkg::*;
#(
  parameter int MAX_LINES = 8,
  parameter int NUM_LINES = 6,
  parameter int IDX_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [MAX_LINES-1:0]   irq_in,
  input  logic                   prio_wr_en,
  input  logic [IDX_W-1:0]       prio_wr_idx,
  input  logic [PRIO_W-1:0]      prio_wr_data,
  output logic [MAX_LINES-1:0]   pending,
  output logic [PRIO_LEVELS-1:0] prio_summary,
  output logic                   cpu_irq,
  output logic [PRIO_W-1:0]      top_prio,
  output logic [IDX_W-1:0]       top_line
);
  logic [MAX_LINES-1:0][PRIO_W-1:0] prio_all;

  irq_pend_capture #(.MAX_LINES(MAX_LINES), .NUM_LINES(NUM_LINES)) u_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pend_q(pending)
  );

  irq_prio_bank #(.MAX_LINES(MAX_LINES), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(prio_wr_en), .wr_idx(prio_wr_idx),
    .wr_data(prio_wr_data), .prio_q(prio_all)
  );

  irq_prio_summary #(.MAX_LINES(MAX_LINES), .IDX_W(IDX_W)) u_summary (
    .pend(pending), .prio(prio_all), .summary(prio_summary),
    .top_prio(top_prio), .top_line(top_line)
  );

  assign cpu_irq = |prio_summary;
endmodule

// File: rtl/irq_prio_pend_ctrl_chk.sv
module irq_prio_pend_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int MAX_LINES = 8,
  parameter int NUM_LINES = 6,
  parameter int IDX_W     = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [MAX_LINES-1:0]   irq_in,
  input logic [MAX_LINES-1:0]   pending,
  input logic [PRIO_LEVELS-1:0] prio_summary,
  input logic                   cpu_irq,
  input logic [PRIO_W-1:0]      top_prio,
  input logic [IDX_W-1:0]       top_line
);
  localparam logic [MAX_LINES-1:0] LIVE = (MAX_LINES'(1) << NUM_LINES) - MAX_LINES'(1);

  logic [MAX_LINES-1:0]   sel_pend;
  logic [PRIO_LEVELS-1:0] below_top;
  assign sel_pend  = pending >> (top_line - IDX_W'(FIRST_LINE));
  assign below_top = prio_summary & ((PRIO_LEVELS'(1) << top_prio) - PRIO_LEVELS'(1));

  assert_line_raises_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_in & LIVE)) |=> cpu_irq);

  assert_idle_drops_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(irq_in & LIVE)) |=> (!cpu_irq && prio_summary == '0));

  assert_top_is_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (prio_summary[top_prio] && below_top == '0));

  assert_top_line_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (top_line >= IDX_W'(FIRST_LINE) && sel_pend[0]));

  assert_dead_inputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~LIVE) == '0);
endmodule

bind irq_prio_pend_ctrl irq_prio_pend_ctrl_chk #(
  .MAX_LINES(MAX_LINES), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pending(pending),
  .prio_summary(prio_summary), .cpu_irq(cpu_irq), .top_prio(top_prio),
  .top_line(top_line)
);

// File: tb/irq_prio_pend_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_pend_ctrl_bench;
  localparam int ML = 8;
  localparam int NL = 6;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [ML-1:0] irq_in;
  logic          prio_wr_en;
  logic [IW-1:0] prio_wr_idx;
  logic [3:0]    prio_wr_data;
  logic [ML-1:0] pending;
  logic [15:0]   prio_summary;
  logic          cpu_irq;
  logic [3:0]    top_prio;
  logic [IW-1:0] top_line;

  int checks = 0;
  int errors = 0;
  int mprio [ML];
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_pend_ctrl #(.MAX_LINES(ML), .NUM_LINES(NL), .IDX_W(IW)) u_irq_prio_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .prio_wr_en(prio_wr_en),
    .prio_wr_idx(prio_wr_idx), .prio_wr_data(prio_wr_data), .pending(pending),
    .prio_summary(prio_summary), .cpu_irq(cpu_irq), .top_prio(top_prio),
    .top_line(top_line)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Compare all outputs with the value computed from the line pattern
  // that was sampled at the last rising edge and the mirrored priorities.
  task automatic check_model(logic [ML-1:0] lines);
    int exp_pend = 0, exp_sum = 0, exp_tp = 0, exp_tl = 0;
    for (int k = 0; k < NL; k++)
      if (lines[k]) begin
        exp_pend |= (1 << k);
        exp_sum  |= (1 << mprio[k]);
      end
    for (int p = 15; p >= 0; p--) if (exp_sum[p]) exp_tp = p;
    for (int k = NL - 1; k >= 0; k--) if (exp_pend[k] && mprio[k] == exp_tp) exp_tl = 16 + k;
    chk("R2/R10 pending", int'(pending), exp_pend);
    chk("R3 summary", int'(prio_summary), exp_sum);
    chk("R5 cpu_irq", int'(cpu_irq), (exp_sum != 0) ? 1 : 0);
    chk("R6 top_prio", int'(top_prio), exp_tp);
    chk("R7 top_line", int'(top_line), exp_tl);
  endtask

  task automatic apply(logic [ML-1:0] lines);
    irq_in = lines;
    @(posedge clk);
    @(negedge clk);
    check_model(lines);
  endtask

  task automatic wr(int idx, int val);
    prio_wr_en   = 1'b1;
    prio_wr_idx  = IW'(idx);
    prio_wr_data = 4'(val);
    @(posedge clk);
    @(negedge clk);
    prio_wr_en = 1'b0;
    if (idx >= 16 && idx < 16 + NL) mprio[idx - 16] = val;
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; prio_wr_en = 1'b0; prio_wr_idx = '0; prio_wr_data = '0;
    for (int k = 0; k < ML; k++) mprio[k] = 15;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk("R1 pending", int'(pending), 0);
    chk("R1 cpu_irq", int'(cpu_irq), 0);
    chk("R1 summary", int'(prio_summary), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 top_line", int'(top_line), 0);
    // R1: priorities reset to least urgent level 15
    irq_in = 8'h01;
    @(posedge clk); @(negedge clk);
    chk("R1 reset prio", int'(prio_summary), 1 << 15);
    chk("R1 reset top_prio", int'(top_prio), 15);
    apply('0);

    // Sweep: three priority layouts, all 256 input patterns each (R2,R3,R5,R6,R7,R10)
    for (int cfg = 0; cfg < 3; cfg++) begin
      for (int k = 0; k < NL; k++)
        wr(16 + k, (cfg == 0) ? (k * 7 + 3) % 16 : (cfg == 1) ? (k % 2) * 5 : 9);
      for (int pat = 0; pat < 256; pat++) apply(ML'(pat));
    end

    // R4: shared level survives release of one line
    for (int k = 0; k < NL; k++) wr(16 + k, 4);
    apply(8'b0000_0101);
    apply(8'b0000_0100);
    chk("R4 shared bit kept", int'(prio_summary), 1 << 4);
    chk("R4 top_line", int'(top_line), 18);
    apply(8'b0000_0000);
    chk("R4 all released", int'(cpu_irq), 0);

    // R8: reprogram a pending line, summary moves the same cycle it lands
    apply(8'b0000_0010);
    wr(17, 1);
    chk("R8 moved level", int'(prio_summary), 1 << 1);
    chk("R8 top_prio", int'(top_prio), 1);
    check_model(8'b0000_0010);

    // R9: reserved and out-of-range indices write nothing
    wr(1, 0);
    wr(15, 0);
    wr(16 + NL, 0);
    wr(16 + ML - 1, 0);
    apply(8'b0011_1111);
    chk("R9 ignored writes", int'(prio_summary), (1 << 4) | (1 << 1));
    chk("R9 top_line", int'(top_line), 17);

    // R10: dead positions alone raise nothing
    apply(8'b1100_0000);
    chk("R10 dead lines", int'(cpu_irq), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule